// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This controller takes a wide bank of interrupt lines, split into equal-sized groups, plus one non-maskable line, and hands the CPU a single prioritised request. All lines are captured into per-group request registers on every clock edge. Arbitration works on whole groups, not on single lines. A group is pending when any of its captured lines is high. Each group has a priority register that holds a two-bit level and a handler offset. The CPU's per-level mask bits and its global mask bit are applied to the pending groups. The winner is then presented as a registered valid flag, a level, an NMI flag and the winning group's offset.

Software sets up the priority registers through a small register port. Once an interrupt is taken, it reads back a request register to find out which line inside the winning group fired. Four cause registers, one per level, report the lowest-numbered pending group at each level. This lets an autovector be formed for any level.

The output stage is a three-state machine:
- `ST_IDLE`: no request.
- `ST_MASKABLE`: an unmasked group wins.
- `ST_NMI`: the captured non-maskable line is high.

Transitions:
- Any state goes to `ST_NMI` while the captured NMI is high.
- `ST_IDLE` goes to `ST_MASKABLE` when an unmasked group appears.
- `ST_MASKABLE` goes to `ST_IDLE` when no unmasked group remains.
- `ST_NMI` falls to `ST_MASKABLE` or `ST_IDLE` when the NMI drops, depending on whether an unmasked group remains.

Top module: `grp_irq_ctrl`

## Requirements
- R1: On every rising clock edge, line i is captured into bit (i mod GRP_W) of the request register of group (i / GRP_W).
- R2: A group is pending exactly when its request register is nonzero; which line set it does not matter.
- R3: A priority register holds the level in bits 31:30 and the offset in bits OFF_W-1:0; other bits read as 0, and a write updates only those two fields.
- R4: While reset is low, all priority registers, request registers and outputs are zero.
- R5: A group at level n is not a valid request while cpu_mask_i[n] is 1.
- R6: While gm_i is 1, no group produces a valid request.
- R7: Among valid groups the highest level wins; at equal levels the lowest-numbered group wins; the winner's offset is output.
- R8: A captured NMI ignores all masks and beats every group: irq_valid_o=1, irq_nmi_o=1, irq_level_o=3, irq_offset_o=0.
- R9: The outputs updated at edge k use the request registers and priority registers as they stood before edge k, and the mask inputs present at edge k.
- R10: A cause read for level L returns bit 31 = some group at level L is pending (masks ignored), and in its low bits the lowest such group number; otherwise 0.
- R11: reg_addr_i top two bits pick the kind: 0 priority, 1 request, 2 cause, 3 reserved (reads 0). The low bits pick the group (or the level for a cause read). Writes to kinds other than 0 are ignored. Reads are combinational.
- R12: While irq_valid_o is 0, irq_nmi_o, irq_level_o and irq_offset_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_GROUPS*GRP_W | Maskable interrupt lines |
| nmi_i | input | 1 | Non-maskable interrupt line |
| cpu_mask_i | input | 4 | Per-level mask bits from the CPU |
| gm_i | input | 1 | Global mask bit from the CPU |
| reg_addr_i | input | 2+SEL_W | Register kind and index |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_valid_o | output | 1 | Request presented to the CPU |
| irq_nmi_o | output | 1 | Request is the non-maskable one |
| irq_level_o | output | 2 | Winning level |
| irq_offset_o | output | OFF_W | Offset of the winning group |

## Verification
The bench uses four groups of sixteen lines (64 lines in all) and a 14-bit offset. With only four groups, two groups can be placed at the same level to exercise the tie rule. The top offset value 0x3FFF and the group boundary lines (bits 15/16, 31/32) are also reachable. A behavioural model steps the request capture and the registered outputs one edge apart. It also sweeps random line patterns, mask settings and priority rewrites.

// File: rtl/irc_pkg.sv
package irc_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 4;
    localparam int DATA_W  = 32;
    localparam int LVL_LSB = 30;

    typedef enum logic [1:0] {
        KIND_PRIO  = 2'd0,
        KIND_REQ   = 2'd1,
        KIND_CAUSE = 2'd2,
        KIND_RSVD  = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_MASKABLE = 2'd1,
        ST_NMI      = 2'd2
    } arb_state_e;
endpackage

// File: rtl/irc_sample.sv
module irc_sample #(
    parameter int N_GROUPS = 4,
    parameter int GRP_W    = 16,
    localparam int N_LINES = N_GROUPS * GRP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LINES-1:0]  irq_i,
    input  logic                nmi_i,
    output logic [N_LINES-1:0]  irr_o,
    output logic [N_GROUPS-1:0] grp_req_o,
    output logic                nmi_q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_o   <= '0;
            nmi_q_o <= 1'b0;
        end else begin
            irr_o   <= irq_i;
            nmi_q_o <= nmi_i;
        end
    end

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_or
        assign grp_req_o[g] = |irr_o[g*GRP_W +: GRP_W];
    end
endmodule

// File: rtl/irc_prio_regs.sv
module irc_prio_regs #(
    parameter int N_GROUPS = 4,
    parameter int OFF_W    = 14,
    localparam int GIDX_W  = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [GIDX_W-1:0]               grp_i,
    input  logic [1:0]                      lvl_i,
    input  logic [OFF_W-1:0]                off_i,
    output logic [N_GROUPS-1:0][1:0]        lvl_o,
    output logic [N_GROUPS-1:0][OFF_W-1:0]  off_o
);
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_o[g] <= '0;
                off_o[g] <= '0;
            end else if (we_i && grp_i == GIDX_W'(g)) begin
                lvl_o[g] <= lvl_i;
                off_o[g] <= off_i;
            end
        end
    end
endmodule

// File: rtl/irc_level_pick.sv
module irc_level_pick #(
    parameter int N_GROUPS = 4,
    localparam int GIDX_W  = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic [N_GROUPS-1:0]            grp_req_i,
    input  logic [N_GROUPS-1:0][1:0]       lvl_i,
    output logic [3:0]                     found_o,
    output logic [3:0][GIDX_W-1:0]         idx_o
);
    for (genvar l = 0; l < 4; l++) begin : g_lvl
        always_comb begin
            found_o[l] = 1'b0;
            idx_o[l]   = '0;
            for (int g = 0; g < N_GROUPS; g++) begin
                if (!found_o[l] && grp_req_i[g] && lvl_i[g] == 2'(l)) begin
                    found_o[l] = 1'b1;
                    idx_o[l]   = GIDX_W'(g);
                end
            end
        end
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
    import irc_pkg::*;
#(
    parameter int N_GROUPS = 4,
    parameter int GRP_W    = 16,
    parameter int OFF_W    = 14,
    localparam int N_LINES = N_GROUPS * GRP_W,
    localparam int GIDX_W  = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
    localparam int SEL_W   = (GIDX_W > 2) ? GIDX_W : 2,
    localparam int ADDR_W  = 2 + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic               nmi_i,
    input  logic [3:0]         cpu_mask_i,
    input  logic               gm_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_we_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               irq_valid_o,
    output logic               irq_nmi_o,
    output logic [1:0]         irq_level_o,
    output logic [OFF_W-1:0]   irq_offset_o
);
    logic [N_LINES-1:0]             irr_flat;
    logic [N_GROUPS-1:0]            grp_req;
    logic                           nmi_q;
    logic [N_GROUPS-1:0][1:0]       lvl_q;
    logic [N_GROUPS-1:0][OFF_W-1:0] off_q;
    logic [3:0]                     lvl_found;
    logic [3:0][GIDX_W-1:0]         lvl_idx;
    logic [3:0]                     lvl_valid;
    logic                           any_valid;
    logic [1:0]                     win_lvl;
    logic [OFF_W-1:0]               win_off;
    arb_state_e                     state_q, state_d;
    logic [1:0]                     level_q;
    logic [OFF_W-1:0]               off_out_q;

    reg_kind_e          kind;
    logic [SEL_W-1:0]   sel;
    logic [GIDX_W-1:0]  sel_g;
    logic               sel_ok;
    logic               prio_we;
    logic               unused_wdata;

    assign kind   = reg_kind_e'(reg_addr_i[ADDR_W-1 -: 2]);
    assign sel    = reg_addr_i[SEL_W-1:0];
    assign sel_g  = sel[GIDX_W-1:0];
    assign sel_ok = int'(sel) < N_GROUPS;
    assign prio_we = reg_we_i && kind == KIND_PRIO && sel_ok;
    assign unused_wdata = ^reg_wdata_i[LVL_LSB-1:OFF_W];

    irc_sample #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W)) u_sample (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .nmi_i     (nmi_i),
        .irr_o     (irr_flat),
        .grp_req_o (grp_req),
        .nmi_q_o   (nmi_q)
    );

    irc_prio_regs #(.N_GROUPS(N_GROUPS), .OFF_W(OFF_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (prio_we),
        .grp_i (sel_g),
        .lvl_i (reg_wdata_i[LVL_LSB +: LVL_W]),
        .off_i (reg_wdata_i[OFF_W-1:0]),
        .lvl_o (lvl_q),
        .off_o (off_q)
    );

    irc_level_pick #(.N_GROUPS(N_GROUPS)) u_pick (
        .grp_req_i (grp_req),
        .lvl_i     (lvl_q),
        .found_o   (lvl_found),
        .idx_o     (lvl_idx)
    );

    // masking and highest-level selection
    always_comb begin
        any_valid = 1'b0;
        win_lvl   = 2'd0;
        for (int l = 0; l < NUM_LVL; l++) begin
            lvl_valid[l] = lvl_found[l] && !cpu_mask_i[l] && !gm_i;
            if (lvl_valid[l]) begin
                any_valid = 1'b1;
                win_lvl   = 2'(l);
            end
        end
        win_off = off_q[lvl_idx[win_lvl]];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (nmi_q)          state_d = ST_NMI;
                else if (any_valid) state_d = ST_MASKABLE;
            end
            ST_MASKABLE: begin
                if (nmi_q)           state_d = ST_NMI;
                else if (!any_valid) state_d = ST_IDLE;
            end
            ST_NMI: begin
                if (!nmi_q) state_d = any_valid ? ST_MASKABLE : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q   <= '0;
            off_out_q <= '0;
        end else begin
            unique case (state_d)
                ST_NMI: begin
                    level_q   <= 2'd3;
                    off_out_q <= '0;
                end
                ST_MASKABLE: begin
                    level_q   <= win_lvl;
                    off_out_q <= win_off;
                end
                default: begin
                    level_q   <= '0;
                    off_out_q <= '0;
                end
            endcase
        end
    end

    assign irq_valid_o  = state_q != ST_IDLE;
    assign irq_nmi_o    = state_q == ST_NMI;
    assign irq_level_o  = level_q;
    assign irq_offset_o = off_out_q;

    // register read port
    always_comb begin
        reg_rdata_o = '0;
        unique case (kind)
            KIND_PRIO: begin
                if (sel_ok) begin
                    reg_rdata_o[LVL_LSB +: LVL_W] = lvl_q[sel_g];
                    reg_rdata_o[OFF_W-1:0]        = off_q[sel_g];
                end
            end
            KIND_REQ: begin
                if (sel_ok) reg_rdata_o[GRP_W-1:0] = irr_flat[sel_g*GRP_W +: GRP_W];
            end
            KIND_CAUSE: begin
                reg_rdata_o[31]         = lvl_found[sel[1:0]];
                reg_rdata_o[GIDX_W-1:0] = lvl_idx[sel[1:0]];
            end
            default: reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
    parameter int N_LINES = 64,
    parameter int OFF_W   = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irq_i,
    input logic [3:0]         cpu_mask_i,
    input logic               gm_i,
    input logic [N_LINES-1:0] irr_flat,
    input logic               nmi_q,
    input logic               irq_valid_o,
    input logic               irq_nmi_o,
    input logic [1:0]         irq_level_o,
    input logic [OFF_W-1:0]   irq_offset_o
);
    logic       started_q;
    logic [3:0] mask_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            mask_d    <= '0;
        end else begin
            started_q <= 1'b1;
            mask_d    <= cpu_mask_i;
        end
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> irr_flat == $past(irq_i));

    p_nmi_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi_o |-> (irq_valid_o && irq_level_o == 2'd3 && irq_offset_o == '0));

    p_nmi_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |=> irq_nmi_o);

    p_global_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gm_i && !nmi_q) |=> !irq_valid_o);

    p_level_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && !irq_nmi_o) |-> !mask_d[irq_level_o]);

    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> (!irq_nmi_o && irq_level_o == 2'd0 && irq_offset_o == '0));
endmodule

bind grp_irq_ctrl irc_checker #(.N_LINES(N_LINES), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_i        (irq_i),
    .cpu_mask_i   (cpu_mask_i),
    .gm_i         (gm_i),
    .irr_flat     (irr_flat),
    .nmi_q        (nmi_q),
    .irq_valid_o  (irq_valid_o),
    .irq_nmi_o    (irq_nmi_o),
    .irq_level_o  (irq_level_o),
    .irq_offset_o (irq_offset_o)
);

// File: tb/test_grp_irq_ctrl.sv
`timescale 1ns/1ps
module test_grp_irq_ctrl;
    localparam int N_GROUPS = 4;
    localparam int GRP_W    = 16;
    localparam int OFF_W    = 14;
    localparam int N_LINES  = N_GROUPS * GRP_W;
    localparam int ADDR_W   = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_LINES-1:0] irq = '0;
    logic               nmi = 1'b0;
    logic [3:0]         cmask = '0;
    logic               gm = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic               we = 1'b0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic               vld, isnmi;
    logic [1:0]         lvl;
    logic [OFF_W-1:0]   off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [GRP_W-1:0] m_irr [N_GROUPS];
    int               m_lvl [N_GROUPS];
    int               m_off [N_GROUPS];
    bit               m_nmi;
    bit               e_vld, e_nmi;
    int               e_lvl, e_off;

    always #2 clk = ~clk;

    grp_irq_ctrl #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W), .OFF_W(OFF_W)) i_grp_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi), .cpu_mask_i(cmask), .gm_i(gm),
        .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_valid_o(vld), .irq_nmi_o(isnmi), .irq_level_o(lvl), .irq_offset_o(off));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata();
        int kind = int'(addr[3:2]);
        int s    = int'(addr[1:0]);
        logic [31:0] r = '0;
        if (kind == 0) begin
            r = (32'(m_lvl[s]) << 30) | 32'(m_off[s]);
        end else if (kind == 1) begin
            r = 32'(m_irr[s]);
        end else if (kind == 2) begin
            for (int g = N_GROUPS - 1; g >= 0; g--)
                if (m_irr[g] != 0 && m_lvl[g] == s) r = 32'h8000_0000 | 32'(g);
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int g = 0; g < N_GROUPS; g++) begin
            m_irr[g] = '0; m_lvl[g] = 0; m_off[g] = 0;
        end
        m_nmi = 0; e_vld = 0; e_nmi = 0; e_lvl = 0; e_off = 0;
    endtask

    // one clock: model steps at the edge, then compare 1 ns later
    task automatic tick(string ctx);
        int best_g;
        int best_l;
        @(posedge clk);
        best_g = -1; best_l = -1;
        if (!gm) begin
            for (int l = 0; l < 4; l++) begin
                if (!cmask[l]) begin
                    for (int g = N_GROUPS - 1; g >= 0; g--)
                        if (m_irr[g] != 0 && m_lvl[g] == l) begin best_g = g; best_l = l; end
                end
            end
        end
        if (m_nmi) begin
            e_vld = 1; e_nmi = 1; e_lvl = 3; e_off = 0;
        end else if (best_g >= 0) begin
            e_vld = 1; e_nmi = 0; e_lvl = best_l; e_off = m_off[best_g];
        end else begin
            e_vld = 0; e_nmi = 0; e_lvl = 0; e_off = 0;
        end
        if (we && addr[3:2] == 2'd0) begin
            m_lvl[addr[1:0]] = int'(wdata[31:30]);
            m_off[addr[1:0]] = int'(wdata[OFF_W-1:0]);
        end
        for (int g = 0; g < N_GROUPS; g++) m_irr[g] = irq[g*GRP_W +: GRP_W];
        m_nmi = nmi;
        #1;
        chk({ctx, " R7 R12 valid"}, 32'(vld), 32'(e_vld));
        chk({ctx, " R8 nmi"},       32'(isnmi), 32'(e_nmi));
        chk({ctx, " R7 level"},     32'(lvl), 32'(e_lvl));
        chk({ctx, " R7 offset"},    32'(off), 32'(e_off));
        chk({ctx, " R11 rdata"},    rdata, exp_rdata());
    endtask

    task automatic wr(int kind, int sel, logic [31:0] d, string ctx);
        addr = ADDR_W'((kind << 2) | sel); we = 1'b1; wdata = d;
        tick(ctx);
        we = 1'b0;
    endtask

    task automatic rd(int kind, int sel, string ctx);
        addr = ADDR_W'((kind << 2) | sel);
        tick(ctx);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        #9;
        // R4: reset state
        chk("R4 valid", 32'(vld), 0);
        chk("R4 level", 32'(lvl), 0);
        chk("R4 offset", 32'(off), 0);
        chk("R4 prio read", rdata, 0);
        irq = 64'hFFFF_FFFF_FFFF_FFFF; nmi = 1'b1;
        #1;
        chk("R4 valid held in reset", 32'(vld), 0);
        irq = '0; nmi = 1'b0;
        #1 rst_n = 1'b1;
        tick("R4");

        // R3: priority layout; reserved bits ignored
        wr(0, 3, 32'hFFFF_FFFF, "R3 full word");
        rd(0, 3, "R3 readback");
        chk("R3 reserved bits zero", rdata, 32'hC000_3FFF);
        wr(0, 0, 32'h4000_0100, "R3");
        wr(0, 1, 32'hC000_02AB, "R3");
        wr(0, 2, 32'hC000_3FFF, "R3");
        wr(0, 3, 32'h0000_0005, "R3");
        rd(0, 1, "R3");
        chk("R3 group1 word", rdata, 32'hC000_02AB);

        // R1 R2 R9: one line in group 2, two-edge path to output
        irq[35] = 1'b1;
        rd(1, 2, "R1 R9 first edge");
        chk("R9 not yet valid", 32'(vld), 0);
        chk("R1 request bit 3", rdata, 32'h0000_0008);
        tick("R2 R9 second edge");
        chk("R2 group2 wins", 32'(off), 32'h3FFF);

        // R7: tie at level 3, lowest group wins
        irq[16] = 1'b1;
        tick("R7"); tick("R7 tie");
        chk("R7 tie offset", 32'(off), 32'h02AB);

        // R5: mask level 3, level 1 group 0 takes over
        irq[0] = 1'b1; cmask = 4'b1000;
        tick("R5"); tick("R5 level mask");
        chk("R5 level", 32'(lvl), 1);

        // R6: global mask blocks all
        gm = 1'b1;
        tick("R6"); tick("R6 global mask");
        chk("R6 valid", 32'(vld), 0);

        // R8: nmi through all masks
        nmi = 1'b1; cmask = 4'hF;
        tick("R8"); tick("R8 nmi");
        chk("R8 nmi flag", 32'(isnmi), 1);
        nmi = 1'b0; gm = 1'b0; cmask = 4'h0;
        tick("R8 release"); tick("R8 release");

        // R10: cause registers
        rd(2, 3, "R10 cause level3");
        chk("R10 level3 group1", rdata, 32'h8000_0001);
        rd(2, 2, "R10 cause empty level");
        chk("R10 level2 empty", rdata, 32'h0);

        // R11: writes to non-priority kinds ignored, reserved reads 0
        wr(1, 1, 32'h0, "R11 write request kind");
        wr(2, 3, 32'h0, "R11 write cause kind");
        wr(3, 0, 32'hFFFF_FFFF, "R11 write reserved kind");
        rd(3, 0, "R11 reserved read");
        chk("R11 reserved zero", rdata, 0);
        rd(0, 1, "R11 prio untouched");
        chk("R11 group1 unchanged", rdata, 32'hC000_02AB);
        rd(1, 1, "R11 request untouched");
        chk("R11 request group1", rdata, 32'h0000_0001);

        // random sweep, compared every clock
        for (int i = 0; i < 400; i++) begin
            irq   = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            nmi   = ($urandom % 16) == 0;
            cmask = 4'($urandom);
            gm    = ($urandom % 8) == 0;
            addr  = ADDR_W'($urandom);
            we    = ($urandom % 6) == 0;
            wdata = $urandom;
            tick("R1 R2 R5 R6 R9 R10 sweep");
        end
        we = 1'b0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule